// File: doc/BRIEF.md
# MII management register file

This block is the station-management register space of an Ethernet PHY. It holds thirty-two 16-bit registers, selected by a 5-bit register number and reached through a parallel port. That port takes the place of the serial management frame decoder: each access carries a PHY address, a register number, a direction and write data. A read result comes back one cycle later.

While reset is held, the block samples a 5-bit PHY address from strap inputs and keeps it for as long as it runs. An access is accepted when its PHY address equals the captured address or is zero. Any other access is dropped: writes change nothing and reads return all ones.

The control register at index 0 has writable mode bits, an isolate bit and a self-clearing soft-reset bit. A captured address of zero keeps the isolate bit set. Register 25 reports the captured address and the speed status input. The remaining indexes are constant identity and status words, general read/write registers, or reserved holes.

Top module: `mii_mgmt_regfile`

## Requirements
- R1: While rst_n is low, strap_addr is captured as the PHY address. Once rst_n rises, register 0 reads CTRL_RST with bits 15 and 6:0 cleared, and rd_valid is 0.
- R2: An access is accepted only when acc_phy equals the captured address or equals 5'b00000. A rejected write changes no register, and a rejected read returns 16'hFFFF.
- R3: A read access (acc_valid=1, acc_write=0) makes rd_valid 1 with its rd_data on the following cycle. A cycle without a read access makes rd_valid 0 on the following cycle.
- R4: Register indexes 7 to 17 and 29 to 31 are reserved: writes to them are ignored and reads return 16'h0000.
- R5: Indexes 4, 5, 6, 18 to 24 and 26 to 28 are general registers: all 16 bits are written and read back. Index 4 resets to ADV_RST and the others reset to zero.
- R6: Index 1 reads STATUS_VAL, index 2 reads ID_HI and index 3 reads ID_LO. Writes to these indexes are ignored.
- R7: Index 25 reads the captured address in bits 4:0 and the speed_10 input in bit 6 (1 = 10 Mbps, 0 = 100 Mbps); all other bits read 0. Writes to it are ignored.
- R8: In register 0, bits 14:7 are written from the write data and bits 6:0 always read 0. isolate_o equals register 0 bit 10.
- R9: When the captured address is 5'b00000, register 0 bit 10 (isolate) reads 1 and isolate_o is 1, even after a write of 0 to that bit.
- R10: An accepted write to register 0 with bit 15 set returns register 0 and every general register to its reset value, and leaves the captured address as it is. Register 0 bit 15 reads 1 on the next cycle and 0 from the cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap_addr is captured while it is low |
| strap_addr | input | 5 | PHY address strap pins |
| speed_10 | input | 1 | Speed status, 1 = 10 Mbps, shown in register 25 bit 6 |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_phy | input | 5 | PHY address carried by the access |
| acc_reg | input | 5 | Register index |
| acc_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 16 | Read result |
| isolate_o | output | 1 | Isolate mode, register 0 bit 10 |

## Verification
Read data and rd_valid are due exactly one clock edge after the read access. The bench drives each access half a period before an edge and samples on the following falling edge. A write takes effect at the edge that accepts it, so a read issued back-to-back on the next cycle already returns the new value. The soft-reset bit is set by that same edge and is cleared by the next one. Two back-to-back reads of register 0 after a soft reset therefore expect bit 15 set and then clear. isolate_o follows a write to register 0 on the next falling edge.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

    localparam int REG_AW   = 5;
    localparam int PHY_AW   = 5;
    localparam int DATA_W   = 16;
    localparam int NUM_REGS = 1 << REG_AW;

    // control register bit positions
    localparam int CTRL_SRST_BIT = 15;
    localparam int CTRL_ISO_BIT  = 10;
    localparam int CTRL_WR_MSB   = 14;
    localparam int CTRL_WR_LSB   = 7;
    // strap/status register bit position
    localparam int SPD_BIT       = 6;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [2:0] {
        K_CTRL,
        K_CONST,
        K_RW,
        K_STRAP,
        K_RSVD
    } reg_kind_e;

    typedef struct packed {
        word_t                          ctrl;
        logic [PHY_AW-1:0]              phy_addr;
        logic                           rd_valid;
        word_t                          rd_data;
        logic [NUM_REGS-1:0][DATA_W-1:0] gen;
    } state_t;

    function automatic reg_kind_e kind_of(input logic [REG_AW-1:0] idx);
        reg_kind_e k;
        if (idx == 0)        k = K_CTRL;
        else if (idx <= 3)   k = K_CONST;
        else if (idx <= 6)   k = K_RW;
        else if (idx <= 17)  k = K_RSVD;
        else if (idx == 25)  k = K_STRAP;
        else if (idx <= 28)  k = K_RW;
        else                 k = K_RSVD;
        return k;
    endfunction

    function automatic word_t ctrl_wr_mask();
        word_t m = '0;
        for (int b = CTRL_WR_LSB; b <= CTRL_WR_MSB; b++) m[b] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/mii_addr_match.sv
module mii_addr_match #(
    parameter int PHY_AW = 5
) (
    input  logic [PHY_AW-1:0] own_addr,
    input  logic [PHY_AW-1:0] req_addr,
    output logic              hit
);
    // own address, or the all-zero broadcast address
    always_comb begin
        hit = (req_addr == own_addr) || (req_addr == '0);
    end
endmodule

// File: rtl/mii_rd_mux.sv
module mii_rd_mux
    import mii_mgmt_pkg::*;
#(
    parameter logic [DATA_W-1:0] STATUS_VAL = 16'h7809,
    parameter logic [DATA_W-1:0] ID_HI      = 16'h0C3A,
    parameter logic [DATA_W-1:0] ID_LO      = 16'h91F2
) (
    input  logic [REG_AW-1:0]                 reg_idx,
    input  word_t                             ctrl,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]   gen,
    input  logic [PHY_AW-1:0]                 own_addr,
    input  logic                              speed_10,
    output word_t                             rword
);
    always_comb begin
        rword = '0;
        unique case (kind_of(reg_idx))
            K_CTRL:  rword = ctrl;
            K_CONST: begin
                if (reg_idx == 1)      rword = STATUS_VAL;
                else if (reg_idx == 2) rword = ID_HI;
                else                   rword = ID_LO;
            end
            K_RW:    rword = gen[reg_idx];
            K_STRAP: begin
                rword[PHY_AW-1:0] = own_addr;
                rword[SPD_BIT]    = speed_10;
            end
            default: rword = '0;
        endcase
    end
endmodule

// File: rtl/mii_mgmt_regfile.sv
module mii_mgmt_regfile
    import mii_mgmt_pkg::*;
#(
    parameter logic [DATA_W-1:0] CTRL_RST   = 16'h1000,
    parameter logic [DATA_W-1:0] ADV_RST    = 16'h01E1,
    parameter logic [DATA_W-1:0] STATUS_VAL = 16'h7809,
    parameter logic [DATA_W-1:0] ID_HI      = 16'h0C3A,
    parameter logic [DATA_W-1:0] ID_LO      = 16'h91F2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        strap_addr,
    input  logic              speed_10,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [4:0]        acc_phy,
    input  logic [4:0]        acc_reg,
    input  logic [15:0]       acc_wdata,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic              isolate_o
);
    localparam word_t WR_MASK = ctrl_wr_mask();
    localparam word_t CTRL_BASE = CTRL_RST & WR_MASK;

    state_t st_q, st_d, st_rst;

    logic [NUM_REGS-1:0][DATA_W-1:0] gen_rst;
    logic                            hit;
    logic                            addr_zero;
    word_t                           rword;
    logic [PHY_AW-1:0]               own_addr;
    word_t                           ctrl_word;

    assign own_addr  = st_q.phy_addr;
    assign ctrl_word = st_q.ctrl;
    assign addr_zero = (st_q.phy_addr == '0);

    // reset value of each general register
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_rst
        if (i == 4) begin : g_adv
            assign gen_rst[i] = ADV_RST;
        end else begin : g_zero
            assign gen_rst[i] = '0;
        end
    end

    mii_addr_match #(.PHY_AW(PHY_AW)) match_i (
        .own_addr (st_q.phy_addr),
        .req_addr (acc_phy),
        .hit      (hit)
    );

    mii_rd_mux #(
        .STATUS_VAL (STATUS_VAL),
        .ID_HI      (ID_HI),
        .ID_LO      (ID_LO)
    ) rmux_i (
        .reg_idx  (acc_reg),
        .ctrl     (st_q.ctrl),
        .gen      (st_q.gen),
        .own_addr (st_q.phy_addr),
        .speed_10 (speed_10),
        .rword    (rword)
    );

    // state loaded while reset is held: strap captured here
    always_comb begin
        st_rst                    = '0;
        st_rst.phy_addr           = strap_addr;
        st_rst.gen                = gen_rst;
        st_rst.ctrl               = CTRL_BASE;
        st_rst.ctrl[CTRL_ISO_BIT] = CTRL_BASE[CTRL_ISO_BIT] | (strap_addr == '0);
    end

    always_comb begin
        st_d                     = st_q;
        st_d.ctrl[CTRL_SRST_BIT] = 1'b0;
        st_d.rd_valid            = acc_valid && !acc_write;
        st_d.rd_data             = '0;
        if (acc_valid && !acc_write) begin
            st_d.rd_data = hit ? rword : '1;
        end
        if (acc_valid && acc_write && hit) begin
            unique case (kind_of(acc_reg))
                K_CTRL: begin
                    if (acc_wdata[CTRL_SRST_BIT]) begin
                        st_d.gen                 = gen_rst;
                        st_d.ctrl                = CTRL_BASE;
                        st_d.ctrl[CTRL_SRST_BIT] = 1'b1;
                    end else begin
                        st_d.ctrl = acc_wdata & WR_MASK;
                    end
                end
                K_RW:    st_d.gen[acc_reg] = acc_wdata;
                default: ;
            endcase
        end
        st_d.ctrl[CTRL_ISO_BIT] = st_d.ctrl[CTRL_ISO_BIT] | addr_zero;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign rd_valid  = st_q.rd_valid;
    assign rd_data   = st_q.rd_data;
    assign isolate_o = st_q.ctrl[CTRL_ISO_BIT];

endmodule

// File: rtl/mii_mgmt_regfile_chk.sv
module mii_mgmt_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [4:0]  acc_phy,
    input logic [4:0]  acc_reg,
    input logic        rd_valid,
    input logic [15:0] rd_data,
    input logic        isolate_o,
    input logic [4:0]  own_addr,
    input logic [15:0] ctrl_word
);
    logic rd_acc, miss, rsvd;
    assign rd_acc = acc_valid && !acc_write;
    assign miss   = (acc_phy != own_addr) && (acc_phy != 5'd0);
    assign rsvd   = ((acc_reg >= 5'd7) && (acc_reg <= 5'd17)) || (acc_reg >= 5'd29);

    // R3
    rd_valid_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rd_valid);

    // R3
    no_spurious_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> !rd_valid);

    // R2
    miss_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && miss) |=> (rd_data == 16'hFFFF));

    // R4
    rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && !miss && rsvd) |=> (rd_data == 16'h0000));

    // R9
    iso_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_addr == 5'd0) |-> isolate_o);

    // R10
    srst_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[15] |=> !ctrl_word[15]);

    // R10
    srst_keeps_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[15] |-> $stable(own_addr));
endmodule

bind mii_mgmt_regfile mii_mgmt_regfile_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_phy   (acc_phy),
    .acc_reg   (acc_reg),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .isolate_o (isolate_o),
    .own_addr  (own_addr),
    .ctrl_word (ctrl_word)
);

// File: tb/mii_mgmt_regfile_tb_top.sv
`timescale 1ns/1ps
module mii_mgmt_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap_addr = 5'd6;
    logic        speed_10 = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [4:0]  acc_phy = '0;
    logic [4:0]  acc_reg = '0;
    logic [15:0] acc_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        isolate_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    mii_mgmt_regfile dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_addr (strap_addr),
        .speed_10   (speed_10),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_phy    (acc_phy),
        .acc_reg    (acc_reg),
        .acc_wdata  (acc_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .isolate_o  (isolate_o)
    );

    typedef struct packed {
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] wd;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    // strap 6, speed_10 = 1; back-to-back accesses
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'd6, 5'd0,  16'h0000, 16'h1000, 4'd1},  // R1 ctrl reset
        '{1'b0, 5'd6, 5'd25, 16'h0000, 16'h0046, 4'd1},  // R1 strap captured
        '{1'b1, 5'd6, 5'd4,  16'hA5A5, 16'h0000, 4'd5},
        '{1'b0, 5'd6, 5'd4,  16'h0000, 16'hA5A5, 4'd5},  // R5
        '{1'b1, 5'd0, 5'd18, 16'h1234, 16'h0000, 4'd2},  // R2 broadcast write
        '{1'b0, 5'd6, 5'd18, 16'h0000, 16'h1234, 4'd2},
        '{1'b1, 5'd9, 5'd18, 16'hFFFF, 16'h0000, 4'd2},  // R2 miss write
        '{1'b0, 5'd6, 5'd18, 16'h0000, 16'h1234, 4'd2},
        '{1'b0, 5'd9, 5'd18, 16'h0000, 16'hFFFF, 4'd2},  // R2 miss read
        '{1'b1, 5'd6, 5'd7,  16'hBEEF, 16'h0000, 4'd4},
        '{1'b0, 5'd6, 5'd7,  16'h0000, 16'h0000, 4'd4},  // R4
        '{1'b1, 5'd6, 5'd31, 16'h1111, 16'h0000, 4'd4},
        '{1'b0, 5'd0, 5'd31, 16'h0000, 16'h0000, 4'd4},  // R4
        '{1'b1, 5'd6, 5'd2,  16'h0000, 16'h0000, 4'd6},
        '{1'b0, 5'd6, 5'd2,  16'h0000, 16'h0C3A, 4'd6},  // R6
        '{1'b0, 5'd6, 5'd3,  16'h0000, 16'h91F2, 4'd6},
        '{1'b0, 5'd6, 5'd1,  16'h0000, 16'h7809, 4'd6},
        '{1'b1, 5'd6, 5'd25, 16'hFFFF, 16'h0000, 4'd7},
        '{1'b0, 5'd6, 5'd25, 16'h0000, 16'h0046, 4'd7},  // R7
        '{1'b1, 5'd6, 5'd0,  16'h64FF, 16'h0000, 4'd8},
        '{1'b0, 5'd6, 5'd0,  16'h0000, 16'h6480, 4'd8},  // R8
        '{1'b1, 5'd6, 5'd28, 16'h0F0F, 16'h0000, 4'd5},
        '{1'b0, 5'd6, 5'd28, 16'h0000, 16'h0F0F, 4'd5},
        '{1'b1, 5'd6, 5'd0,  16'h8000, 16'h0000, 4'd10}, // R10 soft reset
        '{1'b0, 5'd6, 5'd0,  16'h0000, 16'h9000, 4'd10},
        '{1'b0, 5'd6, 5'd0,  16'h0000, 16'h1000, 4'd10},
        '{1'b0, 5'd6, 5'd4,  16'h0000, 16'h01E1, 4'd10},
        '{1'b0, 5'd6, 5'd28, 16'h0000, 16'h0000, 4'd10},
        '{1'b0, 5'd6, 5'd25, 16'h0000, 16'h0046, 4'd10}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, result sampled one falling edge later
    task automatic access(input string tag, input logic wr, input logic [4:0] phy,
                          input logic [4:0] rg, input logic [15:0] wd, input logic [15:0] exp);
        acc_valid = 1'b1;
        acc_write = wr;
        acc_phy   = phy;
        acc_reg   = rg;
        acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0;
        if (wr) check({tag, " rd_valid after write (R3)"}, {15'd0, rd_valid}, 16'd0);
        else begin
            check({tag, " rd_valid (R3)"}, {15'd0, rd_valid}, 16'd1);
            check(tag, rd_data, exp);
        end
    endtask

    task automatic do_reset(input logic [4:0] strap);
        rst_n      = 1'b0;
        strap_addr = strap;
        repeat (3) @(negedge clk);
        rst_n      = 1'b1;
        strap_addr = ~strap;   // straps only matter during reset
    endtask

    initial begin
        #(5ns * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset(5'd6);
        check("R1 rd_valid after reset", {15'd0, rd_valid}, 16'd0);
        check("R1 isolate_o after reset", {15'd0, isolate_o}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            access($sformatf("vec%0d R%0d", i, VECS[i].req), VECS[i].wr, VECS[i].phy,
                   VECS[i].rg, VECS[i].wd, VECS[i].exp);
        end

        // R8: isolate_o follows control bit 10
        access("R8 set isolate", 1'b1, 5'd6, 5'd0, 16'h0400, 16'h0);
        check("R8 isolate_o high", {15'd0, isolate_o}, 16'd1);
        access("R8 clear isolate", 1'b1, 5'd6, 5'd0, 16'h0000, 16'h0);
        check("R8 isolate_o low", {15'd0, isolate_o}, 16'd0);
        // R3: idle cycle gives no read result
        @(negedge clk);
        check("R3 idle rd_valid", {15'd0, rd_valid}, 16'd0);

        // strap address zero, 100 Mbps
        speed_10 = 1'b0;
        do_reset(5'd0);
        check("R9 isolate_o after reset", {15'd0, isolate_o}, 16'd1);
        access("R9 ctrl read", 1'b0, 5'd0, 5'd0, 16'h0, 16'h1400);
        access("R7 speed 100", 1'b0, 5'd0, 5'd25, 16'h0, 16'h0000);
        access("R9 write zero", 1'b1, 5'd0, 5'd0, 16'h0000, 16'h0);
        access("R9 isolate stays", 1'b0, 5'd0, 5'd0, 16'h0, 16'h0400);
        check("R9 isolate_o stays", {15'd0, isolate_o}, 16'd1);
        access("R2 miss at addr0", 1'b0, 5'd5, 5'd0, 16'h0, 16'hFFFF);
        access("R10 soft reset addr0", 1'b1, 5'd0, 5'd0, 16'h8000, 16'h0);
        access("R10 bit15 set", 1'b0, 5'd0, 5'd0, 16'h0, 16'h9400);
        access("R10 bit15 clear", 1'b0, 5'd0, 5'd0, 16'h0, 16'h1400);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule